// File: doc/BRIEF.md
# Sensor Serial Frame Port

This block is the device end of a 16-clock serial link for a four-channel sensor digitizer. When the host pulls chip-select low, the block takes a snapshot of one 12-bit sample. It picks that sample from four parallel input buses: rate, temperature, auxiliary 1 and auxiliary 2. It then shifts out a reply frame on the serial data output, one bit per SCLK falling edge. The same falling edges shift in a 12-bit control word from the host. That word selects the channel and the number coding for the following frame, never the current one.

The serial clock, chip-select and data-in pins are passed through two-flop synchronisers and edge-detected in the fast system clock domain. The output has a separate enable, so the pad can be three-stated. The control logic is a three-state machine:

- ST_IDLE: the output is disabled. It moves to ST_SHIFT when chip-select falls.
- ST_SHIFT: the frame is in progress. It returns to ST_IDLE if chip-select rises early, and goes to ST_DONE on the 16th falling edge.
- ST_DONE: the output is disabled and the block waits. It returns to ST_IDLE when chip-select rises.

Top module: `sensor_frame_port`

## Requirements
- R1: After reset the output enable is low, the selected channel is 0 (rate) and the coding is straight binary.
- R2: A chip-select fall raises the output enable, and the first reply bit, which is a zero, is driven before the first SCLK fall.
- R3: The reply is MSB first: reply bits 1–2 are zero, bits 3–4 are the channel code of the sample, and bits 5–16 are sample bits 11 down to 0. Bit k is valid before the k-th SCLK fall, and the output advances on each fall.
- R4: Channel code 00 selects rate, 01 temperature, 10 aux 1 and 11 aux 2. The code is taken from control bits 7:6.
- R5: The control word is shifted in MSB first. If its bit 11 (first bit) is 0, the stored channel and coding stay unchanged.
- R6: Control bit 0 set to 1 selects straight binary. Set to 0, it selects twos complement, which is the unsigned sample with its MSB inverted.
- R7: Only the data-in values at the first 12 SCLK falls form the control word. The values at falls 13–16 have no effect.
- R8: The output enable drops after the 16th SCLK fall.
- R9: If chip-select rises before the 16th fall, the output enable drops and the stored control is not updated.
- R10: The sample is snapshotted at the chip-select fall. Input changes during the frame do not alter the reply.
- R11: A control word written in a frame takes effect only from the next frame. The current reply keeps the old channel and coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from host, idles high |
| cs_n_in | input | 1 | Active-low chip-select |
| din_in | input | 1 | Serial control data from host |
| rate_smp | input | 12 | Rate sample, unsigned (channel 00) |
| temp_smp | input | 12 | Temperature sample, unsigned (channel 01) |
| aux1_smp | input | 12 | Aux 1 sample, unsigned (channel 10) |
| aux2_smp | input | 12 | Aux 2 sample, unsigned (channel 11) |
| dout | output | 1 | Serial reply data, forced low when disabled |
| dout_oe | output | 1 | Output enable for the three-state pad |

## Verification
The same SCLK fall moves the reply out and takes a control bit in. The 16th fall also commits the new control word while the last reply bit is still on the pin. The bench checks each frame that carries a new control word: the whole reply must still show the previous channel tag and coding, and the next frame must use the new ones. The case where chip-select rises just before the committing fall is provoked by frames cut short after 13 falls and after 3 falls. It is judged by the channel tag and coding of the frame that follows.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int SMP_W        = 12;
    localparam int NCH          = 4;
    localparam int CH_W         = $clog2(NCH);
    localparam int LEAD_W       = 2;
    localparam int FRAME_LEN    = LEAD_W + CH_W + SMP_W;
    localparam int CTL_W        = 12;
    localparam int CTL_WR_BIT   = 11;
    localparam int CTL_CH_LSB   = 6;
    localparam int CTL_CODE_BIT = 0;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } frame_st_t;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfp_reply_fmt.sv
module sfp_reply_fmt import sfp_pkg::*; #(
    parameter int SW = SMP_W,
    parameter int NC = NCH,
    localparam int CW = $clog2(NC)
) (
    input  logic [NC*SW-1:0] smp_bus,
    input  logic [CW-1:0]    sel,
    input  logic             straight,
    output logic [SW-1:0]    word
);
    logic [SW-1:0] picked;

    always_comb begin
        picked = smp_bus[sel*SW +: SW];
        if (straight) word = picked;
        else          word = {~picked[SW-1], picked[SW-2:0]};
    end
endmodule

// File: rtl/sfp_frame_fsm.sv
module sfp_frame_fsm import sfp_pkg::*; #(
    parameter int SW   = SMP_W,
    parameter int CW   = CH_W,
    parameter int FLEN = FRAME_LEN,
    parameter int CTLW = CTL_W,
    localparam int CNT_W = $clog2(FLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_s,
    input  logic          din_s,
    input  logic [SW-1:0] reply_word,
    output logic          dout,
    output logic          dout_oe,
    output logic [CW-1:0] cfg_ch,
    output logic          cfg_straight
);
    frame_st_t        state_q, state_d;
    logic             sclk_d, cs_d;
    logic             sclk_fall, cs_fall, cs_rise;
    logic [CNT_W-1:0] fall_cnt;
    logic [FLEN-1:0]  shreg;
    logic [CTLW-1:0]  ctl_sh;
    logic             last_fall;

    assign sclk_fall = sclk_d & ~sclk_s;
    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign last_fall = sclk_fall && (fall_cnt == CNT_W'(FLEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (last_fall) state_d = ST_DONE;
            end
            ST_DONE:  if (cs_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d       <= 1'b1;
            cs_d         <= 1'b1;
            fall_cnt     <= '0;
            shreg        <= '0;
            ctl_sh       <= '0;
            dout_oe      <= 1'b0;
            cfg_ch       <= '0;
            cfg_straight <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        shreg    <= {{LEAD_W{1'b0}}, cfg_ch, reply_word};
                        fall_cnt <= '0;
                        dout_oe  <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        dout_oe <= 1'b0;
                    end else if (sclk_fall) begin
                        fall_cnt <= fall_cnt + 1'b1;
                        shreg    <= {shreg[FLEN-2:0], 1'b0};
                        if (fall_cnt < CNT_W'(CTLW))
                            ctl_sh <= {ctl_sh[CTLW-2:0], din_s};
                        if (last_fall) begin
                            dout_oe <= 1'b0;
                            if (ctl_sh[CTL_WR_BIT]) begin
                                cfg_ch       <= ctl_sh[CTL_CH_LSB +: CW];
                                cfg_straight <= ctl_sh[CTL_CODE_BIT];
                            end
                        end
                    end
                end
                ST_DONE: ;
                default: dout_oe <= 1'b0;
            endcase
        end
    end

    assign dout = dout_oe & shreg[FLEN-1];

    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(cs_fall));
    // R2
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);
    // R8
    frame_end_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && last_fall) |=> !dout_oe);
    // R9
    early_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise) |=> (!dout_oe && $stable(cfg_ch) && $stable(cfg_straight)));
    // R11
    cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_ch) |-> $past(state_q == ST_SHIFT && sclk_fall));
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= CNT_W'(FLEN));
endmodule

// File: rtl/sensor_frame_port.sv
module sensor_frame_port import sfp_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             cs_n_in,
    input  logic             din_in,
    input  logic [SMP_W-1:0] rate_smp,
    input  logic [SMP_W-1:0] temp_smp,
    input  logic [SMP_W-1:0] aux1_smp,
    input  logic [SMP_W-1:0] aux2_smp,
    output logic             dout,
    output logic             dout_oe
);
    logic [2:0]           pins_s;
    logic [NCH*SMP_W-1:0] smp_bus;
    logic [SMP_W-1:0]     reply_word;
    logic [CH_W-1:0]      cfg_ch;
    logic                 cfg_straight;

    sfp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({din_in, cs_n_in, sclk_in}),
        .q     (pins_s)
    );

    assign smp_bus = {aux2_smp, aux1_smp, temp_smp, rate_smp};

    sfp_reply_fmt #(.SW(SMP_W), .NC(NCH)) u_fmt (
        .smp_bus  (smp_bus),
        .sel      (cfg_ch),
        .straight (cfg_straight),
        .word     (reply_word)
    );

    sfp_frame_fsm #(.SW(SMP_W), .CW(CH_W), .FLEN(FRAME_LEN), .CTLW(CTL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (pins_s[0]),
        .cs_s         (pins_s[1]),
        .din_s        (pins_s[2]),
        .reply_word   (reply_word),
        .dout         (dout),
        .dout_oe      (dout_oe),
        .cfg_ch       (cfg_ch),
        .cfg_straight (cfg_straight)
    );
endmodule

// File: tb/sim_sensor_frame_port.sv
module sim_sensor_frame_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
    logic [11:0] s_rate = '0, s_temp = '0, s_aux1 = '0, s_aux2 = '0;
    logic dout, dout_oe;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_ch = 2'd0;
    logic       m_straight = 1'b1;

    logic [15:0] exp_q[$];
    logic [15:0] obs_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sensor_frame_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .cs_n_in(cs_n), .din_in(din),
        .rate_smp(s_rate), .temp_smp(s_temp), .aux1_smp(s_aux1), .aux2_smp(s_aux2),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] pick(input logic [1:0] ch);
        case (ch)
            2'd0: pick = s_rate;
            2'd1: pick = s_temp;
            2'd2: pick = s_aux1;
            default: pick = s_aux2;
        endcase
    endfunction

    task automatic new_samples();
        s_rate = 12'($urandom); s_temp = 12'($urandom);
        s_aux1 = 12'($urandom); s_aux2 = 12'($urandom);
    endtask

    // cut = 16 runs a full scored frame; smaller values abort early (R9)
    task automatic run_frame(input logic [11:0] ctl, input logic [3:0] tail, input int cut, input string tag);
        logic [11:0] s;
        logic [15:0] got;
        new_samples();
        s = pick(m_ch);
        if (cut == 16) begin
            exp_q.push_back({2'b00, m_ch, m_straight ? s : {~s[11], s[10:0]}});
            tag_q.push_back(tag);
        end
        got = '0;
        cs_n = 1'b0;
        wclk(6);
        chk(dout_oe === 1'b1, "R2 oe", {15'd0, dout_oe}, 16'd1);
        for (int k = 1; k <= cut; k++) begin
            din = (k <= 12) ? ctl[12-k] : tail[16-k];
            wclk(6);
            got = {got[14:0], dout};
            sclk = 1'b0;
            wclk(6);
            if (k == 5) new_samples(); // R10: inputs move mid-frame
            sclk = 1'b1;
            wclk(6);
        end
        if (cut == 16) begin
            chk(dout_oe === 1'b0, "R8 oe after 16", {15'd0, dout_oe}, 16'd0);
            obs_q.push_back(got);
            if (ctl[11]) begin
                m_ch = ctl[7:6];
                m_straight = ctl[0];
            end
        end
        cs_n = 1'b1;
        wclk(6);
        if (cut < 16)
            chk(dout_oe === 1'b0, "R9 oe after early rise", {15'd0, dout_oe}, 16'd0);
    endtask

    // monitor
    initial begin
        forever begin
            logic [15:0] e, o;
            string t;
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(o === e, t, o, e);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        chk(dout_oe === 1'b0, "R1 oe after reset", {15'd0, dout_oe}, 16'd0);
        run_frame(12'h000, 4'h0, 16, "R1 reset channel/coding");
        run_frame(12'h871, 4'h0, 16, "R11 old config in current reply"); // write ch=01 straight
        run_frame(12'h000, 4'h0, 16, "R4 channel 01 temp");
        run_frame(12'h8B0, 4'hF, 16, "R10 snapshot");                    // write ch=10 twos, tail ones
        run_frame(12'h0F1, 4'h0, 16, "R7 tail ignored, ch 10 twos");      // write bit clear
        run_frame(12'h000, 4'h0, 16, "R5 write bit 0 keeps config");
        run_frame(12'h8F1, 4'h0, 13, "R9 abort after 13");
        run_frame(12'h8F1, 4'h0, 3,  "R9 abort after 3");
        run_frame(12'h8F0, 4'h0, 16, "R9 config unchanged after abort"); // write ch=11 twos
        run_frame(12'h831, 4'h0, 16, "R6 twos on ch 11");                 // write ch=00 straight
        run_frame(12'h8B0, 4'h0, 16, "R6 straight on ch 00");             // write ch=10 twos
        run_frame(12'h8F1, 4'h0, 16, "R4 channel 10 aux1");               // write ch=11 straight
        for (int i = 0; i < 8; i++) begin
            logic [11:0] c;
            c = {1'($urandom), 1'b0, 2'b00, 2'($urandom), 4'b1100, 1'b0, 1'($urandom)};
            run_frame(c, 4'($urandom), 16, "R3 frame layout");
        end
        wait (obs_q.size() == 0);
        wclk(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule